// File: doc/BRIEF.md
# Oversampled Serial Receiver with Receive Queue

This block receives asynchronous serial characters on a single line. A free-running enable pulses sixteen times per bit period, and all bit timing is taken from those pulses. The line first passes through a two-stage synchronizer. A high-to-low transition seen on a pulse does not by itself start a character. It starts a count, and the line is checked again eight pulses later, at the middle of the start bit. If the line has gone back high by then, the event is treated as noise and dropped. Nothing is written.

Once a start bit is accepted, eight data bits arrive least significant bit first. Each bit and the stop bit are sampled at their centres, sixteen pulses apart. The finished byte is placed in a sixteen-entry queue together with a flag that records a low stop bit. The host sees the oldest entry on its read port while the data-ready output is high, and removes that entry with a one-cycle pop. If a byte completes while the queue is full, the byte is lost and a sticky overrun flag rises. The flag stays high until the host signals a status read.

Top module: `serial_rx_fifo`

## Requirements
- R1: After reset, data_ready and overrun are 0.
- R2: A character whose eight data bits are sent least significant bit first appears at rd_byte with rd_ferr 0 when its stop bit is 1.
- R3: A low pulse on rx that returns high before the start-bit centre (8 tick16 pulses after the edge) stores nothing.
- R4: A 0 sampled at the stop-bit centre stores the byte with rd_ferr 1.
- R5: data_ready is 1 exactly while the queue holds an entry. A pop request while data_ready is 0 has no effect on later contents.
- R6: Bytes leave the queue in arrival order, and up to 16 entries are held.
- R7: A byte completed while 16 entries are held is discarded and sets overrun. Overrun stays 1 until a stat_rd pulse clears it.
- R8: After a character ends with rx still low, no new character starts until rx has been seen high and falls again.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| tick16 | input | 1 | Oversampling enable, 16 pulses per bit |
| rx | input | 1 | Serial input, idle high |
| rd_pop | input | 1 | Remove the head entry |
| stat_rd | input | 1 | Status read, clears overrun |
| rd_byte | output | 8 | Head entry data |
| rd_ferr | output | 1 | Head entry framing-error flag |
| data_ready | output | 1 | Queue non-empty |
| overrun | output | 1 | Sticky lost-byte flag |

## Verification
A receiver state that is one pulse early or late only shows up as wrong bits at rd_byte once a pattern makes neighbouring bits differ. Alternating patterns, along with all-zero and all-one patterns, therefore expose it on the first character. A false-start path that fails to return to idle shows up as a phantom entry within one character time. Queue pointer faults show up as reordered or repeated bytes when a full queue is drained. They also show up as a missing overrun flag after the seventeenth character.

// File: rtl/serial_rx_fifo.sv
module serial_rx_fifo #(
  parameter int OSR   = 16,
  parameter int DEPTH = 16,
  parameter int DW    = 8
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          tick16,
  input  logic          rx,
  input  logic          rd_pop,
  input  logic          stat_rd,
  output logic [DW-1:0] rd_byte,
  output logic          rd_ferr,
  output logic          data_ready,
  output logic          overrun
);
  localparam int CW = $clog2(OSR);
  localparam int AW = $clog2(DEPTH);
  localparam int BW = $clog2(DW);
  localparam logic [CW-1:0] HALF = CW'(OSR/2 - 1);
  localparam logic [CW-1:0] FULLB = CW'(OSR - 1);
  localparam logic [1:0] S_IDLE = 2'd0, S_START = 2'd1, S_DATA = 2'd2, S_STOP = 2'd3;

  logic [1:0]    sync_q;
  logic          rx_sync, rx_prev;
  logic [1:0]    st;
  logic [CW-1:0] cnt;
  logic [BW-1:0] bitn;
  logic [DW-1:0] shreg;
  logic [DW:0]   mem [DEPTH];
  logic [AW:0]   wp, rp, level;
  logic          full, push, drop, pop, at_ctr;

  assign rx_sync = sync_q[1];
  assign level   = wp - rp;
  assign full    = level == (AW+1)'(DEPTH);
  assign data_ready = level != '0;
  assign at_ctr  = tick16 && cnt == FULLB;
  assign push    = st == S_STOP && at_ctr && !full;
  assign drop    = st == S_STOP && at_ctr && full;
  assign pop     = rd_pop && data_ready;
  assign {rd_ferr, rd_byte} = mem[rp[AW-1:0]];

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n) sync_q <= 2'b11;
    else        sync_q <= {sync_q[0], rx};

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st <= S_IDLE; cnt <= '0; bitn <= '0; shreg <= '0; rx_prev <= 1'b1;
    end else if (tick16) begin
      rx_prev <= rx_sync;
      cnt <= cnt + 1'b1;
      case (st)
        S_IDLE:  begin
          cnt <= '0;
          if (rx_prev && !rx_sync) st <= S_START;
        end
        S_START: if (cnt == HALF) begin
          cnt <= '0; bitn <= '0;
          st  <= rx_sync ? S_IDLE : S_DATA;
        end
        S_DATA:  if (cnt == FULLB) begin
          shreg <= {rx_sync, shreg[DW-1:1]};
          bitn  <= bitn + 1'b1;
          if (bitn == BW'(DW-1)) st <= S_STOP;
        end
        default: if (cnt == FULLB) st <= S_IDLE;
      endcase
    end
  end

  always_ff @(posedge clk)
    if (push) mem[wp[AW-1:0]] <= {~rx_sync, shreg};

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      wp <= '0; rp <= '0; overrun <= 1'b0;
    end else begin
      if (push) wp <= wp + 1'b1;
      if (pop)  rp <= rp + 1'b1;
      if (drop)         overrun <= 1'b1;
      else if (stat_rd) overrun <= 1'b0;
    end
  end
endmodule

// File: rtl/serial_rx_fifo_chk.sv
module serial_rx_fifo_chk #(
  parameter int OSR   = 16,
  parameter int DEPTH = 16
) (
  input logic                     clk,
  input logic                     rst_n,
  input logic                     tick16,
  input logic                     rx_sync,
  input logic                     stat_rd,
  input logic                     data_ready,
  input logic                     overrun,
  input logic                     push,
  input logic [1:0]               st,
  input logic [$clog2(OSR)-1:0]   cnt,
  input logic [$clog2(DEPTH):0]   level
);
  localparam int CW = $clog2(OSR);

  AST_RDY_FROM_PUSH: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(data_ready) |-> $past(push)); // R5
  AST_EMPTY_STAYS: assert property (@(posedge clk) disable iff (!rst_n)
    (!data_ready && !push) |=> !data_ready); // R5
  AST_NO_OVERFLOW: assert property (@(posedge clk) disable iff (!rst_n)
    level <= ($clog2(DEPTH)+1)'(DEPTH)); // R6
  AST_OVR_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
    (overrun && !stat_rd) |=> overrun); // R7
  AST_FALSE_START: assert property (@(posedge clk) disable iff (!rst_n)
    (st == 2'd1 && tick16 && cnt == CW'(OSR/2 - 1) && rx_sync) |=> st == 2'd0); // R3
endmodule

bind serial_rx_fifo serial_rx_fifo_chk #(.OSR(OSR), .DEPTH(DEPTH)) u_chk (
  .clk(clk), .rst_n(rst_n), .tick16(tick16), .rx_sync(rx_sync), .stat_rd(stat_rd),
  .data_ready(data_ready), .overrun(overrun), .push(push), .st(st), .cnt(cnt),
  .level(level)
);

// File: tb/sim_serial_rx_fifo.sv
module sim_serial_rx_fifo;
  localparam int CLK_PERIOD = 10;
  localparam int BITCLK = 32;

  logic clk = 1'b0, rst_n = 1'b0, tick16 = 1'b0, rx = 1'b1, rd_pop = 1'b0, stat_rd = 1'b0;
  logic [7:0] rd_byte;
  logic rd_ferr, data_ready, overrun;
  logic [8:0] expq[$];
  int checks = 0, fails = 0;
  bit done = 0;

  serial_rx_fifo u0 (.clk(clk), .rst_n(rst_n), .tick16(tick16), .rx(rx), .rd_pop(rd_pop),
    .stat_rd(stat_rd), .rd_byte(rd_byte), .rd_ferr(rd_ferr), .data_ready(data_ready),
    .overrun(overrun));

  always #(CLK_PERIOD/2) clk = ~clk;

  initial forever begin
    @(negedge clk);
    tick16 = rst_n ? ~tick16 : 1'b0;
  end

  task automatic chk(string req, int act, int exp);
    checks++;
    if (act != exp) begin
      fails++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic idle_bits(int n);
    rx = 1'b1;
    repeat (n*BITCLK) @(negedge clk);
  endtask

  // Driver: sends one character and records the expected queue entry
  task automatic send(logic [7:0] d, logic stop, bit record = 1);
    rx = 1'b0; repeat (BITCLK) @(negedge clk);
    for (int i = 0; i < 8; i++) begin rx = d[i]; repeat (BITCLK) @(negedge clk); end
    rx = stop; repeat (BITCLK) @(negedge clk);
    if (record) expq.push_back({~stop, d});
  endtask

  // Monitor: pops every queued entry and compares it with the scoreboard
  task automatic drain(string req);
    while (data_ready) begin
      logic [8:0] e;
      e = (expq.size() != 0) ? expq.pop_front() : 9'h1ff;
      chk(req, {rd_ferr, rd_byte}, e);
      rd_pop = 1'b1; @(negedge clk); rd_pop = 1'b0; @(negedge clk);
    end
    chk({req, " scoreboard empty"}, expq.size(), 0);
  endtask

  initial begin
    repeat (200000) @(negedge clk);
    if (!done) begin
      fails++; checks++;
      $display("FAIL watchdog actual=timeout expected=finish");
      $display("%0d/%0d checks passed", checks - fails, checks);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    chk("R1 data_ready", data_ready, 0);
    chk("R1 overrun", overrun, 0);
    rst_n = 1'b1;
    idle_bits(2);

    send(8'hA5, 1'b1); idle_bits(1);
    chk("R2 ready", data_ready, 1);
    drain("R2");
    send(8'h00, 1'b1); send(8'hFF, 1'b1); send(8'h3C, 1'b1); idle_bits(1);
    drain("R2 R6 patterns");

    rx = 1'b0; repeat (8) @(negedge clk); idle_bits(2);
    chk("R3 no store", data_ready, 0);
    rx = 1'b0; repeat (12) @(negedge clk); idle_bits(2);
    chk("R3 no store long glitch", data_ready, 0);

    send(8'h5A, 1'b0); idle_bits(1);
    drain("R4 framing");

    rd_pop = 1'b1; @(negedge clk); rd_pop = 1'b0; @(negedge clk);
    chk("R5 empty pop", data_ready, 0);
    send(8'h81, 1'b1); idle_bits(1);
    drain("R5 after empty pop");

    send(8'h96, 1'b0);
    rx = 1'b0; repeat (3*BITCLK) @(negedge clk);
    chk("R8 held low single entry ready", data_ready, 1);
    idle_bits(1);
    drain("R8");

    for (int i = 0; i < 16; i++) send(8'(i*17 + 3), 1'b1);
    idle_bits(1);
    chk("R7 no overrun at 16", overrun, 0);
    send(8'hEE, 1'b1, 0); idle_bits(1);
    chk("R7 overrun set", overrun, 1);
    idle_bits(1);
    chk("R7 overrun held", overrun, 1);
    drain("R6 R7 order");
    chk("R7 overrun held after drain", overrun, 1);
    stat_rd = 1'b1; @(negedge clk); stat_rd = 1'b0; @(negedge clk);
    chk("R7 overrun cleared", overrun, 0);

    done = 1;
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end
endmodule